// File: doc/BRIEF.md
# SPI Transmit/Receive FIFO Status Layer

This block sits between a register bus and an SPI shift engine. It queues outgoing words in a four-entry transmit FIFO and incoming words in a four-entry receive FIFO. For each FIFO it reports an occupancy count and full and empty flags. The bus side pushes transmit words and pops receive words with single-cycle strobes. The engine side takes the transmit head word and delivers each received word with single-cycle strobes.

On top of the two queues the block derives status and interrupt requests. Each FIFO has a threshold status. The receive side uses a strictly-greater comparison and the transmit side uses a less-or-equal comparison. A sticky overrun flag records any received word that was dropped because the receive FIFO was full. A timeout flag reports a receive FIFO that holds data but has been left unread for a fixed number of SPI clock ticks. Each of these four sources is gated by its own enable to form an interrupt request.

Two further controls complete the block. Each FIFO has a self-clearing flush control. In master FIFO mode the block raises a busy signal that starts the shift engine whenever transmit data is queued.

Top module: `spi_fifo_ctrl`

## Requirements
- R1: The transmit FIFO holds up to 4 words and delivers them in write order on `eng_tx_data`. `tx_count` gives the number of held words (0..4). `tx_empty` is 1 exactly when the count is 0, and `tx_full` is 1 exactly when the count is 4.
- R2: The receive FIFO holds up to 4 words and returns them in arrival order on `rx_rd_data`. `rx_count`, `rx_empty` and `rx_full` follow the same rules as their transmit counterparts.
- R3: `rx_thr_sts` is 1 exactly when `rx_count` is strictly greater than `rx_thr`. `irq_rx_thr` equals `rx_thr_sts` AND `rx_thr_ie`.
- R4: `tx_thr_sts` is 1 exactly when `tx_count` is less than or equal to `tx_thr`. `irq_tx_thr` equals `tx_thr_sts` AND `tx_thr_ie`.
- R5: A received word that arrives while the receive FIFO is full is discarded, and the FIFO contents and count stay unchanged. `ovr_flag` is set one cycle later and stays set until `ovr_clr` is pulsed. `irq_ovr` equals `ovr_flag` AND `ovr_ie`.
- R6: While the receive FIFO is non-empty and unread, `tout_flag` is set after the TOUT_TICKS-th `sclk_tick` (default 64) and not before. A receive read clears it, and so does a pulse on `tout_clr`. `irq_tout` equals `tout_flag` AND `tout_ie`.
- R7: A one-cycle pulse on `tx_flush_req` or `rx_flush_req` raises the matching `*_flush_pend` in the next cycle. One cycle after that the pending bit returns to 0, and that FIFO is empty with count 0.
- R8: With `fifo_mode` and `master_mode` both 1, `busy` is 1 one cycle after a transmit write. It stays 1 while transmit words remain, and returns to 0 on the cycle after the last word is taken. Outside master FIFO mode, `busy` is 0.
- R9: A transmit write while the transmit FIFO is full is ignored. The count and the queued words stay unchanged.
- R10: A receive read while the receive FIFO is empty leaves the count at 0. While the FIFO is empty, `rx_rd_data` reads as 0.
- R11: After reset both FIFOs are empty with count 0. `ovr_flag`, `tout_flag`, `busy`, both flush-pending bits and all interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | FIFO mode enable |
| master_mode | input | 1 | 1 = master, 0 = slave |
| tx_wr_en | input | 1 | Bus write strobe to the transmit FIFO |
| tx_wr_data | input | 32 | Word written to the transmit FIFO |
| rx_rd_en | input | 1 | Bus read strobe popping the receive FIFO |
| rx_rd_data | output | 32 | Receive FIFO head word, 0 when empty |
| tx_flush_req | input | 1 | Request to flush the transmit FIFO |
| rx_flush_req | input | 1 | Request to flush the receive FIFO |
| tx_flush_pend | output | 1 | Transmit flush in progress (self-clearing) |
| rx_flush_pend | output | 1 | Receive flush in progress (self-clearing) |
| eng_tx_pop | input | 1 | Engine took the transmit head word |
| eng_tx_data | output | 32 | Transmit head word presented to the engine |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word from the engine |
| sclk_tick | input | 1 | One pulse per SPI clock period |
| rx_thr | input | 2 | Receive threshold |
| tx_thr | input | 2 | Transmit threshold |
| rx_thr_ie | input | 1 | Receive threshold interrupt enable |
| tx_thr_ie | input | 1 | Transmit threshold interrupt enable |
| ovr_ie | input | 1 | Overrun interrupt enable |
| tout_ie | input | 1 | Timeout interrupt enable |
| ovr_clr | input | 1 | Write-1 clear of the overrun flag |
| tout_clr | input | 1 | Write-1 clear of the timeout flag |
| tx_count | output | 4 | Transmit FIFO valid-word count |
| rx_count | output | 4 | Receive FIFO valid-word count |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_thr_sts | output | 1 | Receive threshold status |
| tx_thr_sts | output | 1 | Transmit threshold status |
| ovr_flag | output | 1 | Sticky receive overrun flag |
| tout_flag | output | 1 | Receive timeout flag |
| busy | output | 1 | Automatic start/busy for the master engine |
| irq_rx_thr | output | 1 | Receive threshold interrupt request |
| irq_tx_thr | output | 1 | Transmit threshold interrupt request |
| irq_ovr | output | 1 | Overrun interrupt request |
| irq_tout | output | 1 | Timeout interrupt request |

## Verification
A wrong pointer or count shows up at the ports within one cycle: the count or a flag is off, or a threshold status flips at the wrong fill level. A wrong pointer or a bad write index also reorders or corrupts the words read back at the next pop. A timeout counter that is off by one shows as `tout_flag` rising one tick early or late, so the tick sweep samples the flag after every tick. A busy or overrun register that is not updated correctly shows on the cycle after the write, the pop or the dropped push that should have changed it.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    // registered control state of the top level
    typedef struct packed {
        logic ovr;       // sticky overrun
        logic busy;      // automatic start/busy
        logic tx_flush;  // transmit flush pending
        logic rx_flush;  // receive flush pending
    } ctrl_state_t;

    localparam ctrl_state_t CTRL_RESET = '{ovr: 1'b0, busy: 1'b0, tx_flush: 1'b0, rx_flush: 1'b0};

endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty,
    output logic              drop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wr;
        logic [PTR_W-1:0]             rd;
        logic [CNT_W-1:0]             cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != FULL_CNT) && !flush;
        do_pop  = pop && (st_q.cnt != '0) && !flush;
        if (flush) begin
            st_d.wr  = '0;
            st_d.rd  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wr] = push_data;
                st_d.wr = (st_q.wr == LAST) ? '0 : st_q.wr + 1'b1;
            end
            if (do_pop) begin
                st_d.rd = (st_q.rd == LAST) ? '0 : st_q.rd + 1'b1;
            end
            st_d.cnt = st_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rd];
    assign count = st_q.cnt;
    assign full  = (st_q.cnt == FULL_CNT);
    assign empty = (st_q.cnt == '0);
    assign drop  = push && full && !flush;

endmodule

// File: rtl/spi_rx_timeout.sv
module spi_rx_timeout #(
    parameter int TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nonempty,
    input  logic rd,
    input  logic flush,
    input  logic tick,
    input  logic clr,
    output logic flag
);
    localparam int TW = $clog2(TICKS + 1);
    localparam logic [TW-1:0] LAST_TICK = TW'(TICKS - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          flag;
    } tout_state_t;

    tout_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd || flush || !nonempty) begin
            st_d.cnt = '0;
        end else if (tick && !st_q.flag) begin
            if (st_q.cnt == LAST_TICK) st_d.flag = 1'b1;
            else                       st_d.cnt  = st_q.cnt + 1'b1;
        end
        if (rd || clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl
    import spi_fifo_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int DEPTH      = 4,
    parameter int CNT_W      = 4,
    parameter int THR_W      = 2,
    parameter int TOUT_TICKS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_mode,
    input  logic              master_mode,
    input  logic              tx_wr_en,
    input  logic [DATA_W-1:0] tx_wr_data,
    input  logic              rx_rd_en,
    output logic [DATA_W-1:0] rx_rd_data,
    input  logic              tx_flush_req,
    input  logic              rx_flush_req,
    output logic              tx_flush_pend,
    output logic              rx_flush_pend,
    input  logic              eng_tx_pop,
    output logic [DATA_W-1:0] eng_tx_data,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    input  logic              sclk_tick,
    input  logic [THR_W-1:0]  rx_thr,
    input  logic [THR_W-1:0]  tx_thr,
    input  logic              rx_thr_ie,
    input  logic              tx_thr_ie,
    input  logic              ovr_ie,
    input  logic              tout_ie,
    input  logic              ovr_clr,
    input  logic              tout_clr,
    output logic [CNT_W-1:0]  tx_count,
    output logic [CNT_W-1:0]  rx_count,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              rx_empty,
    output logic              rx_thr_sts,
    output logic              tx_thr_sts,
    output logic              ovr_flag,
    output logic              tout_flag,
    output logic              busy,
    output logic              irq_rx_thr,
    output logic              irq_tx_thr,
    output logic              irq_ovr,
    output logic              irq_tout
);
    ctrl_state_t ctl_d, ctl_q;

    logic [DATA_W-1:0] rx_head;
    logic              rx_drop;
    logic              tx_drop;
    logic              tx_push_ok, tx_pop_ok;
    logic [CNT_W-1:0]  tx_cnt_nxt;

    spi_word_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (ctl_q.tx_flush),
        .push      (tx_wr_en),
        .push_data (tx_wr_data),
        .pop       (eng_tx_pop),
        .head      (eng_tx_data),
        .count     (tx_count),
        .full      (tx_full),
        .empty     (tx_empty),
        .drop      (tx_drop)
    );

    spi_word_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (ctl_q.rx_flush),
        .push      (eng_rx_push),
        .push_data (eng_rx_data),
        .pop       (rx_rd_en),
        .head      (rx_head),
        .count     (rx_count),
        .full      (rx_full),
        .empty     (rx_empty),
        .drop      (rx_drop)
    );

    spi_rx_timeout #(.TICKS(TOUT_TICKS)) u_rx_tout (
        .clk      (clk),
        .rst_n    (rst_n),
        .nonempty (!rx_empty),
        .rd       (rx_rd_en),
        .flush    (ctl_q.rx_flush),
        .tick     (sclk_tick),
        .clr      (tout_clr),
        .flag     (tout_flag)
    );

    always_comb begin
        ctl_d = ctl_q;

        // flush controls stay set for exactly one cycle
        ctl_d.tx_flush = ctl_q.tx_flush ? 1'b0 : tx_flush_req;
        ctl_d.rx_flush = ctl_q.rx_flush ? 1'b0 : rx_flush_req;

        // sticky overrun, set wins over clear
        ctl_d.ovr = (ctl_q.ovr && !ovr_clr) || rx_drop;

        // busy follows the transmit occupancy after this edge
        tx_push_ok = tx_wr_en && !tx_full && !tx_drop && !ctl_q.tx_flush;
        tx_pop_ok  = eng_tx_pop && !tx_empty && !ctl_q.tx_flush;
        tx_cnt_nxt = ctl_q.tx_flush ? '0
                   : tx_count + CNT_W'(tx_push_ok) - CNT_W'(tx_pop_ok);
        ctl_d.busy = fifo_mode && master_mode && (tx_cnt_nxt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTRL_RESET;
        else        ctl_q <= ctl_d;
    end

    assign rx_rd_data    = rx_empty ? '0 : rx_head;
    assign tx_flush_pend = ctl_q.tx_flush;
    assign rx_flush_pend = ctl_q.rx_flush;
    assign ovr_flag      = ctl_q.ovr;
    assign busy          = ctl_q.busy;

    assign rx_thr_sts = (rx_count > CNT_W'(rx_thr));
    assign tx_thr_sts = (tx_count <= CNT_W'(tx_thr));

    assign irq_rx_thr = rx_thr_sts && rx_thr_ie;
    assign irq_tx_thr = tx_thr_sts && tx_thr_ie;
    assign irq_ovr    = ovr_flag && ovr_ie;
    assign irq_tout   = tout_flag && tout_ie;

endmodule

// File: rtl/spi_fifo_ctrl_chk.sv
module spi_fifo_ctrl_chk #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_mode,
    input logic              master_mode,
    input logic              tx_wr_en,
    input logic              eng_tx_pop,
    input logic              eng_rx_push,
    input logic              rx_rd_en,
    input logic [DATA_W-1:0] rx_rd_data,
    input logic              tx_flush_pend,
    input logic              rx_flush_pend,
    input logic [CNT_W-1:0]  tx_count,
    input logic [CNT_W-1:0]  rx_count,
    input logic              tx_full,
    input logic              tx_empty,
    input logic              rx_full,
    input logic              rx_empty,
    input logic              ovr_flag,
    input logic              tout_flag,
    input logic              busy
);
    localparam logic [CNT_W-1:0] MAXC = CNT_W'(DEPTH);

    assert_tx_bounds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= MAXC) && !(tx_full && tx_empty));

    assert_rx_bounds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count <= MAXC) && !(rx_full && rx_empty));

    assert_ovr_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && eng_rx_push && !rx_rd_en && !rx_flush_pend) |=> (ovr_flag && rx_count == MAXC));

    assert_tout_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tout_flag) |-> $past(!rx_empty));

    assert_read_clears_tout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd_en |=> !tout_flag);

    assert_rx_flush_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush_pend |=> (rx_count == '0 && !rx_flush_pend));

    assert_tx_flush_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush_pend |=> (tx_count == '0 && !tx_flush_pend));

    assert_busy_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && master_mode && $past(fifo_mode && master_mode)) |-> (busy == (tx_count != '0)));

    assert_busy_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!(fifo_mode && master_mode)) |-> !busy);

    assert_full_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && tx_wr_en && !eng_tx_pop && !tx_flush_pend) |=> (tx_count == MAXC));

    assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_empty && rx_rd_en && !eng_rx_push) |=> (rx_count == '0));

    assert_empty_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |-> (rx_rd_data == '0));

endmodule

bind spi_fifo_ctrl spi_fifo_ctrl_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_mode     (fifo_mode),
    .master_mode   (master_mode),
    .tx_wr_en      (tx_wr_en),
    .eng_tx_pop    (eng_tx_pop),
    .eng_rx_push   (eng_rx_push),
    .rx_rd_en      (rx_rd_en),
    .rx_rd_data    (rx_rd_data),
    .tx_flush_pend (tx_flush_pend),
    .rx_flush_pend (rx_flush_pend),
    .tx_count      (tx_count),
    .rx_count      (rx_count),
    .tx_full       (tx_full),
    .tx_empty      (tx_empty),
    .rx_full       (rx_full),
    .rx_empty      (rx_empty),
    .ovr_flag      (ovr_flag),
    .tout_flag     (tout_flag),
    .busy          (busy)
);

// File: tb/spi_fifo_ctrl_bench.sv
module spi_fifo_ctrl_bench;
    localparam int DW = 32;
    localparam int DEPTH = 4;
    localparam int TICKS = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_mode = 0, master_mode = 0;
    logic tx_wr_en = 0, rx_rd_en = 0, tx_flush_req = 0, rx_flush_req = 0;
    logic eng_tx_pop = 0, eng_rx_push = 0, sclk_tick = 0;
    logic [DW-1:0] tx_wr_data = '0, eng_rx_data = '0;
    logic [1:0] rx_thr = 0, tx_thr = 0;
    logic rx_thr_ie = 0, tx_thr_ie = 0, ovr_ie = 0, tout_ie = 0, ovr_clr = 0, tout_clr = 0;
    logic [DW-1:0] rx_rd_data, eng_tx_data;
    logic tx_flush_pend, rx_flush_pend;
    logic [3:0] tx_count, rx_count;
    logic tx_full, tx_empty, rx_full, rx_empty, rx_thr_sts, tx_thr_sts;
    logic ovr_flag, tout_flag, busy, irq_rx_thr, irq_tx_thr, irq_ovr, irq_tout;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    spi_fifo_ctrl u_spi_fifo_ctrl (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .master_mode(master_mode),
        .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
        .tx_flush_req(tx_flush_req), .rx_flush_req(rx_flush_req),
        .tx_flush_pend(tx_flush_pend), .rx_flush_pend(rx_flush_pend),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .sclk_tick(sclk_tick),
        .rx_thr(rx_thr), .tx_thr(tx_thr), .rx_thr_ie(rx_thr_ie), .tx_thr_ie(tx_thr_ie),
        .ovr_ie(ovr_ie), .tout_ie(tout_ie), .ovr_clr(ovr_clr), .tout_clr(tout_clr),
        .tx_count(tx_count), .rx_count(rx_count), .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_full(rx_full), .rx_empty(rx_empty), .rx_thr_sts(rx_thr_sts), .tx_thr_sts(tx_thr_sts),
        .ovr_flag(ovr_flag), .tout_flag(tout_flag), .busy(busy),
        .irq_rx_thr(irq_rx_thr), .irq_tx_thr(irq_tx_thr), .irq_ovr(irq_ovr), .irq_tout(irq_tout)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic tx_write(input logic [31:0] d);
        tx_wr_en = 1; tx_wr_data = d; cyc(); tx_wr_en = 0;
    endtask
    task automatic tx_pop();
        eng_tx_pop = 1; cyc(); eng_tx_pop = 0;
    endtask
    task automatic rx_push(input logic [31:0] d);
        eng_rx_push = 1; eng_rx_data = d; cyc(); eng_rx_push = 0;
    endtask
    task automatic rx_read();
        rx_rd_en = 1; cyc(); rx_rd_en = 0;
    endtask
    task automatic tick_once();
        sclk_tick = 1; cyc(); sclk_tick = 0; cyc();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        cyc();

        // R11 reset state
        chk({tx_count, rx_count}, 8'h00, "R11 counts");
        chk({tx_empty, rx_empty, tx_full, rx_full}, 4'b1100, "R11 empty/full");
        chk({ovr_flag, tout_flag, busy, tx_flush_pend, rx_flush_pend}, 5'b0, "R11 flags");
        chk({irq_rx_thr, irq_tx_thr, irq_ovr, irq_tout}, 4'b0, "R11 irqs");

        // R1 / R4 sweep: every fill level, threshold and enable
        for (int k = 0; k <= DEPTH; k++) begin
            if (k > 0) tx_write(32'hA000_0000 + k);
            chk(tx_count, k, "R1 tx count");
            chk({tx_full, tx_empty}, {k == DEPTH, k == 0}, "R1 tx full/empty");
            for (int t = 0; t < 4; t++) begin
                for (int e = 0; e < 2; e++) begin
                    tx_thr = t[1:0]; tx_thr_ie = e[0]; #1;
                    chk(tx_thr_sts, (k <= t), "R4 tx threshold");
                    chk(irq_tx_thr, (k <= t) && (e == 1), "R4 tx irq");
                end
            end
        end
        tx_thr_ie = 0;
        // R9 write to full ignored
        tx_write(32'hDEAD_BEEF);
        chk(tx_count, 4, "R9 full write count");
        for (int k = 1; k <= DEPTH; k++) begin
            chk(eng_tx_data, 32'hA000_0000 + k, "R1 tx order / R9 contents");
            tx_pop();
        end
        chk(tx_empty, 1, "R1 tx drained");

        // R2 / R3 sweep
        for (int k = 0; k <= DEPTH; k++) begin
            if (k > 0) rx_push(32'hB000_0000 + k);
            chk(rx_count, k, "R2 rx count");
            chk({rx_full, rx_empty}, {k == DEPTH, k == 0}, "R2 rx full/empty");
            for (int t = 0; t < 4; t++) begin
                for (int e = 0; e < 2; e++) begin
                    rx_thr = t[1:0]; rx_thr_ie = e[0]; #1;
                    chk(rx_thr_sts, (k > t), "R3 rx threshold");
                    chk(irq_rx_thr, (k > t) && (e == 1), "R3 rx irq");
                end
            end
        end
        rx_thr_ie = 0;
        // R5 overrun: drop, sticky, irq, clear
        rx_push(32'h0BAD_0BAD);
        chk(ovr_flag, 1, "R5 overrun set");
        chk(rx_count, 4, "R5 count kept");
        chk(irq_ovr, 0, "R5 irq gated");
        ovr_ie = 1; #1;
        chk(irq_ovr, 1, "R5 irq enabled");
        cyc(); cyc();
        chk(ovr_flag, 1, "R5 sticky");
        for (int k = 1; k <= DEPTH; k++) begin
            chk(rx_rd_data, 32'hB000_0000 + k, "R2 rx order / R5 drop");
            rx_read();
        end
        ovr_clr = 1; cyc(); ovr_clr = 0;
        chk({ovr_flag, irq_ovr}, 2'b00, "R5 clear");
        ovr_ie = 0;

        // R10 read empty
        chk(rx_rd_data, 0, "R10 empty data");
        rx_read();
        chk(rx_count, 0, "R10 empty read count");

        // R6 timeout via ticks, cleared by read
        rx_push(32'h1234_5678);
        tout_ie = 1;
        for (int i = 1; i < TICKS; i++) begin
            tick_once();
            chk(tout_flag, 0, "R6 no early timeout");
        end
        tick_once();
        chk(tout_flag, 1, "R6 timeout set");
        chk(irq_tout, 1, "R6 irq");
        rx_read();
        chk(tout_flag, 0, "R6 read clears");
        // cleared by write-1
        rx_push(32'h5555_AAAA);
        for (int i = 0; i < TICKS; i++) tick_once();
        chk(tout_flag, 1, "R6 timeout again");
        tout_clr = 1; cyc(); tout_clr = 0;
        chk({tout_flag, irq_tout}, 2'b00, "R6 write-1 clear");
        tout_ie = 0;

        // R7 flushes
        rx_push(1); rx_push(2);
        rx_flush_req = 1; cyc(); rx_flush_req = 0;
        chk({rx_flush_pend, rx_count}, {1'b1, 4'd3}, "R7 rx pend");
        cyc();
        chk({rx_flush_pend, rx_count, rx_empty}, {1'b0, 4'd0, 1'b1}, "R7 rx flushed");
        tx_write(7); tx_write(8);
        tx_flush_req = 1; cyc(); tx_flush_req = 0;
        chk({tx_flush_pend, tx_count}, {1'b1, 4'd2}, "R7 tx pend");
        cyc();
        chk({tx_flush_pend, tx_count, tx_empty}, {1'b0, 4'd0, 1'b1}, "R7 tx flushed");
        tx_write(9);
        chk(eng_tx_data, 9, "R7 tx usable after flush");
        tx_pop();

        // R8 busy
        fifo_mode = 1; master_mode = 1; cyc();
        chk(busy, 0, "R8 idle");
        tx_write(32'hC1);
        chk(busy, 1, "R8 busy on write");
        tx_write(32'hC2);
        tx_pop();
        chk(busy, 1, "R8 busy with words left");
        tx_pop();
        chk(busy, 0, "R8 busy cleared");
        master_mode = 0; cyc();
        tx_write(32'hC3);
        chk(busy, 0, "R8 slave no busy");
        tx_pop();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule